// File: doc/BRIEF.md
# Serial GPIO Bitstream Engine

The engine widens a device's general-purpose I/O by moving up to 128 signals over four pins: a serial clock, a data output, a data input and a latch strobe. Chains of external shift registers hang on these pins. Every serial clock period moves one output bit out and one input bit in. When the last bit of a frame has been shifted, the latch strobe tells the external registers to transfer their contents. Frames repeat for as long as the engine is running.

Signals are arranged as 32 ports with one to four bits each. The linear index of a signal is `bit * 32 + port`. Software sees one 32-bit output word and one 32-bit input word per bit position, and bit `p` of a word belongs to port `p`. A port-enable mask removes whole ports from the stream, which shortens the frame and the refresh latency. On the wire the frame is ordered by port: enabled ports in ascending order, and each port's bits kept together.

Configuration and data go through a simple register port. Writes are synchronous and reads are combinational. Mask, bit count and clock divider are captured at the start of each frame. Captured input bits become visible only when the frame completes.

Top module: `sgpio_engine`

## Requirements
- R1: After reset all four serial pins are low, and every register address reads zero.
- R2: Register map. Address 0 is control: bit 0 run, bits 2:1 hold bits-per-port minus one, bits 23:8 hold the divider D. Address 1 is the port-enable mask, with bit p for port p. Addresses 2 to 5 are output words for bit 0 to bit 3. Addresses 6 to 9 are input words for bit 0 to bit 3 and are read-only: writes to them change nothing.
- R3: A frame has exactly popcount(mask) × n slots. Disabled ports contribute none.
- R4: Slot order is enabled ports ascending. Within each port, bits run from 0 to n-1 before the next port starts. The slot for port p, bit b carries bit p of output word b.
- R5: The input level sampled while the serial clock is high in slot (p, b) is stored in bit p of input word b.
- R6: Input words change only on the cycle the latch strobe falls. Bits of ports or bit positions absent from the frame keep their previous values.
- R7: After the last slot the latch strobe is high for exactly 2·(D+1) cycles, and the serial clock stays low during that time.
- R8: Each serial clock high phase lasts D+1 cycles. Each low phase between two pulses of one frame also lasts D+1 cycles.
- R9: When run is 0 or the mask is all zeros, no frame starts and the three output pins stay low.
- R10: Frames repeat back to back while running. A change to mask, bit count or divider made during a frame takes effect from the next frame on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 4 | Register write address |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | 4 | Register read address |
| reg_rd_data | output | 32 | Register read data (combinational) |
| ser_clk | output | 1 | Serial shift clock |
| ser_dout | output | 1 | Serial output data, stable around the rising edge |
| ser_din | input | 1 | Serial input data, sampled while ser_clk is high |
| ser_latch | output | 1 | End-of-frame transfer strobe |

## Verification
The hardest case to reach is a configuration change that lands in the middle of a running frame. The frame in flight must finish with its old mask, and the next frame must use the new one. The bench waits until a few serial pulses of a wide frame have been seen, then narrows the mask and checks two consecutive frames. Sparse masks such as ports 0, 1, 5, 6 and 7, a single top port, and the full 128-slot frame are driven directly. Random masks, bit counts and divider values fill the space in between. Each random frame carries its own input pattern, and the bench tracks the expected input words across frames so that bits held from earlier frames are checked as well.

// File: rtl/sgpio_pkg.sv
package sgpio_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOW   = 2'd1,
    ST_HIGH  = 2'd2,
    ST_LATCH = 2'd3
  } seq_state_t;

  localparam int ADDR_CTRL     = 0;
  localparam int ADDR_MASK     = 1;
  localparam int ADDR_OUT_BASE = 2;
  localparam int CTRL_DIV_LSB  = 8;

endpackage

// File: rtl/sgpio_port_finder.sv
module sgpio_port_finder #(
  parameter int NUM_PORTS = 32,
  parameter int PW        = 5
) (
  input  logic [NUM_PORTS-1:0] mask,
  input  logic [PW:0]          from,
  output logic                 found,
  output logic [PW-1:0]        port
);

  localparam int FW = PW + 1;

  // lowest enabled port at or above 'from'
  always_comb begin
    found = 1'b0;
    port  = '0;
    for (int i = NUM_PORTS - 1; i >= 0; i--) begin
      if (mask[i] && (FW'(i) >= from)) begin
        found = 1'b1;
        port  = PW'(i);
      end
    end
  end

endmodule

// File: rtl/sgpio_divider.sv
module sgpio_divider #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] limit,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == limit);

  always_comb begin
    if (restart || tick) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/sgpio_regs.sv
module sgpio_regs
  import sgpio_pkg::*;
#(
  parameter int NUM_PORTS = 32,
  parameter int MAX_BITS  = 4,
  parameter int DIV_W     = 16,
  parameter int ADDR_W    = 4,
  parameter int BW        = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [NUM_PORTS-1:0]          wr_data,
  input  logic [ADDR_W-1:0]             rd_addr,
  output logic [NUM_PORTS-1:0]          rd_data,
  output logic                          run,
  output logic [BW-1:0]                 nb_sel,
  output logic [DIV_W-1:0]              div,
  output logic [NUM_PORTS-1:0]          mask,
  output logic [MAX_BITS*NUM_PORTS-1:0] out_flat,
  input  logic                          commit,
  input  logic [MAX_BITS*NUM_PORTS-1:0] cap_flat,
  output logic [MAX_BITS*NUM_PORTS-1:0] in_flat
);

  localparam int IN_BASE = ADDR_OUT_BASE + MAX_BITS;
  localparam int FLAT    = MAX_BITS * NUM_PORTS;

  logic             run_q, run_d;
  logic [BW-1:0]    nb_q, nb_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [NUM_PORTS-1:0] mask_q, mask_d;
  logic [FLAT-1:0]  out_q, out_d;
  logic [FLAT-1:0]  in_q, in_d;

  always_comb begin
    run_d  = run_q;
    nb_d   = nb_q;
    div_d  = div_q;
    mask_d = mask_q;
    out_d  = out_q;
    if (wr_en) begin
      if (wr_addr == ADDR_W'(ADDR_CTRL)) begin
        run_d = wr_data[0];
        nb_d  = wr_data[BW:1];
        div_d = wr_data[CTRL_DIV_LSB +: DIV_W];
      end
      if (wr_addr == ADDR_W'(ADDR_MASK)) mask_d = wr_data;
      for (int k = 0; k < MAX_BITS; k++) begin
        if (wr_addr == ADDR_W'(ADDR_OUT_BASE + k)) out_d[k*NUM_PORTS +: NUM_PORTS] = wr_data;
      end
    end
    in_d = commit ? cap_flat : in_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      nb_q   <= '0;
      div_q  <= '0;
      mask_q <= '0;
      out_q  <= '0;
      in_q   <= '0;
    end else begin
      run_q  <= run_d;
      nb_q   <= nb_d;
      div_q  <= div_d;
      mask_q <= mask_d;
      out_q  <= out_d;
      in_q   <= in_d;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(ADDR_CTRL)) begin
      rd_data[0]                        = run_q;
      rd_data[BW:1]                     = nb_q;
      rd_data[CTRL_DIV_LSB +: DIV_W]    = div_q;
    end
    if (rd_addr == ADDR_W'(ADDR_MASK)) rd_data = mask_q;
    for (int k = 0; k < MAX_BITS; k++) begin
      if (rd_addr == ADDR_W'(ADDR_OUT_BASE + k)) rd_data = out_q[k*NUM_PORTS +: NUM_PORTS];
      if (rd_addr == ADDR_W'(IN_BASE + k))       rd_data = in_q[k*NUM_PORTS +: NUM_PORTS];
    end
  end

  assign run      = run_q;
  assign nb_sel   = nb_q;
  assign div      = div_q;
  assign mask     = mask_q;
  assign out_flat = out_q;
  assign in_flat  = in_q;

endmodule

// File: rtl/sgpio_sequencer.sv
module sgpio_sequencer
  import sgpio_pkg::*;
#(
  parameter int NUM_PORTS = 32,
  parameter int MAX_BITS  = 4,
  parameter int DIV_W     = 16,
  parameter int BW        = 2,
  parameter int PW        = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          run,
  input  logic [NUM_PORTS-1:0]          mask,
  input  logic [BW-1:0]                 nb_sel,
  input  logic [DIV_W-1:0]              div,
  input  logic [MAX_BITS*NUM_PORTS-1:0] out_flat,
  input  logic                          sdi,
  input  logic                          tick,
  output logic                          restart,
  output logic [DIV_W-1:0]              fdiv,
  output logic                          sclk,
  output logic                          sdo,
  output logic                          load,
  output logic                          commit,
  output logic [MAX_BITS*NUM_PORTS-1:0] cap_flat,
  output logic                          active
);

  localparam int FLAT = MAX_BITS * NUM_PORTS;
  localparam logic [BW-1:0] NB_MAX = BW'(MAX_BITS - 1);

  seq_state_t           state_q, state_d;
  logic [PW-1:0]        port_q, port_d;
  logic [BW-1:0]        bit_q, bit_d;
  logic [NUM_PORTS-1:0] fmask_q, fmask_d;
  logic [BW-1:0]        fnb_q, fnb_d;
  logic [DIV_W-1:0]     fdiv_q, fdiv_d;
  logic                 half_q, half_d;
  logic                 sdo_q, sdo_d;
  logic                 sclk_q, load_q;
  logic [FLAT-1:0]      cap_q, cap_d;

  logic          first_found, next_found;
  logic [PW-1:0] first_port, next_port;
  logic          start_ok;
  logic [BW-1:0] nb_clamped;

  sgpio_port_finder #(.NUM_PORTS(NUM_PORTS), .PW(PW)) i_first (
    .mask (mask),
    .from ('0),
    .found(first_found),
    .port (first_port)
  );

  sgpio_port_finder #(.NUM_PORTS(NUM_PORTS), .PW(PW)) i_next (
    .mask (fmask_q),
    .from ({1'b0, port_q} + 1'b1),
    .found(next_found),
    .port (next_port)
  );

  assign start_ok   = run && first_found;
  assign nb_clamped = (nb_sel > NB_MAX) ? NB_MAX : nb_sel;

  always_comb begin
    state_d = state_q;
    port_d  = port_q;
    bit_d   = bit_q;
    fmask_d = fmask_q;
    fnb_d   = fnb_q;
    fdiv_d  = fdiv_q;
    half_d  = half_q;
    sdo_d   = sdo_q;
    cap_d   = cap_q;
    commit  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_ok) begin
          state_d = ST_LOW;
          port_d  = first_port;
          bit_d   = '0;
          fmask_d = mask;
          fnb_d   = nb_clamped;
          fdiv_d  = div;
          sdo_d   = out_flat[int'(first_port)];
        end
      end
      ST_LOW: begin
        if (tick) state_d = ST_HIGH;
      end
      ST_HIGH: begin
        if (tick) begin
          cap_d[int'(bit_q)*NUM_PORTS + int'(port_q)] = sdi;
          if (bit_q != fnb_q) begin
            bit_d   = bit_q + 1'b1;
            state_d = ST_LOW;
            sdo_d   = out_flat[(int'(bit_q) + 1)*NUM_PORTS + int'(port_q)];
          end else if (next_found) begin
            port_d  = next_port;
            bit_d   = '0;
            state_d = ST_LOW;
            sdo_d   = out_flat[int'(next_port)];
          end else begin
            state_d = ST_LATCH;
            half_d  = 1'b0;
            sdo_d   = 1'b0;
          end
        end
      end
      ST_LATCH: begin
        if (tick) begin
          if (!half_q) begin
            half_d = 1'b1;
          end else begin
            commit = 1'b1;
            if (start_ok) begin
              state_d = ST_LOW;
              port_d  = first_port;
              bit_d   = '0;
              fmask_d = mask;
              fnb_d   = nb_clamped;
              fdiv_d  = div;
              sdo_d   = out_flat[int'(first_port)];
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      port_q  <= '0;
      bit_q   <= '0;
      fmask_q <= '0;
      fnb_q   <= '0;
      fdiv_q  <= '0;
      half_q  <= 1'b0;
      sdo_q   <= 1'b0;
      sclk_q  <= 1'b0;
      load_q  <= 1'b0;
      cap_q   <= '0;
    end else begin
      state_q <= state_d;
      port_q  <= port_d;
      bit_q   <= bit_d;
      fmask_q <= fmask_d;
      fnb_q   <= fnb_d;
      fdiv_q  <= fdiv_d;
      half_q  <= half_d;
      sdo_q   <= sdo_d;
      sclk_q  <= (state_d == ST_HIGH);
      load_q  <= (state_d == ST_LATCH);
      cap_q   <= cap_d;
    end
  end

  assign restart  = (state_q == ST_IDLE);
  assign fdiv     = fdiv_q;
  assign sclk     = sclk_q;
  assign sdo      = sdo_q;
  assign load     = load_q;
  assign cap_flat = cap_q;
  assign active   = (state_q != ST_IDLE);

endmodule

// File: rtl/sgpio_engine.sv
module sgpio_engine #(
  parameter int NUM_PORTS = 32,
  parameter int MAX_BITS  = 4,
  parameter int DIV_W     = 16,
  parameter int ADDR_W    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr_en,
  input  logic [ADDR_W-1:0]    reg_wr_addr,
  input  logic [NUM_PORTS-1:0] reg_wr_data,
  input  logic [ADDR_W-1:0]    reg_rd_addr,
  output logic [NUM_PORTS-1:0] reg_rd_data,
  output logic                 ser_clk,
  output logic                 ser_dout,
  input  logic                 ser_din,
  output logic                 ser_latch
);

  localparam int BW   = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1;
  localparam int PW   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam int FLAT = MAX_BITS * NUM_PORTS;

  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic                 cfg_run;
  logic [BW-1:0]        cfg_nb;
  logic [DIV_W-1:0]     cfg_div;
  logic [NUM_PORTS-1:0] cfg_mask;
  logic [FLAT-1:0]      out_flat, in_flat, cap_flat;
  logic                 commit, tick, restart, seq_active;
  logic [DIV_W-1:0]     seq_fdiv;

  sgpio_regs #(
    .NUM_PORTS(NUM_PORTS), .MAX_BITS(MAX_BITS), .DIV_W(DIV_W), .ADDR_W(ADDR_W), .BW(BW)
  ) i_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (reg_wr_en),
    .wr_addr (reg_wr_addr),
    .wr_data (reg_wr_data),
    .rd_addr (reg_rd_addr),
    .rd_data (reg_rd_data),
    .run     (cfg_run),
    .nb_sel  (cfg_nb),
    .div     (cfg_div),
    .mask    (cfg_mask),
    .out_flat(out_flat),
    .commit  (commit),
    .cap_flat(cap_flat),
    .in_flat (in_flat)
  );

  sgpio_divider #(.DIV_W(DIV_W)) i_div (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .restart(restart),
    .limit  (seq_fdiv),
    .tick   (tick)
  );

  sgpio_sequencer #(
    .NUM_PORTS(NUM_PORTS), .MAX_BITS(MAX_BITS), .DIV_W(DIV_W), .BW(BW), .PW(PW)
  ) i_seq (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run     (cfg_run),
    .mask    (cfg_mask),
    .nb_sel  (cfg_nb),
    .div     (cfg_div),
    .out_flat(out_flat),
    .sdi     (ser_din),
    .tick    (tick),
    .restart (restart),
    .fdiv    (seq_fdiv),
    .sclk    (ser_clk),
    .sdo     (ser_dout),
    .load    (ser_latch),
    .commit  (commit),
    .cap_flat(cap_flat),
    .active  (seq_active)
  );

endmodule

// File: rtl/sgpio_engine_chk.sv
module sgpio_engine_chk #(
  parameter int NUM_PORTS = 32,
  parameter int MAX_BITS  = 4,
  parameter int DIV_W     = 16
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          ser_clk,
  input logic                          ser_latch,
  input logic                          ser_dout,
  input logic                          active,
  input logic                          run,
  input logic [NUM_PORTS-1:0]          mask,
  input logic [DIV_W-1:0]              fdiv,
  input logic [MAX_BITS*NUM_PORTS-1:0] in_flat
);

  localparam int CW = DIV_W + 2;

  logic [CW-1:0] hcnt_q, lcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q <= '0;
      lcnt_q <= '0;
    end else begin
      hcnt_q <= ser_clk   ? hcnt_q + 1'b1 : '0;
      lcnt_q <= ser_latch ? lcnt_q + 1'b1 : '0;
    end
  end

  assert_high_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_clk) |-> (hcnt_q == CW'($past(fdiv)) + CW'(1)));

  assert_latch_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_latch) |-> (lcnt_q == ((CW'($past(fdiv)) + CW'(1)) << 1)));

  assert_no_clk_in_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ser_clk && ser_latch));

  assert_inputs_atomic_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(in_flat) |-> $fell(ser_latch));

  assert_idle_pins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!ser_clk && !ser_latch && !ser_dout));

  assert_start_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(run && (|mask)));

endmodule

bind sgpio_engine sgpio_engine_chk #(
  .NUM_PORTS(NUM_PORTS), .MAX_BITS(MAX_BITS), .DIV_W(DIV_W)
) i_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .ser_clk  (ser_clk),
  .ser_latch(ser_latch),
  .ser_dout (ser_dout),
  .active   (seq_active),
  .run      (cfg_run),
  .mask     (cfg_mask),
  .fdiv     (seq_fdiv),
  .in_flat  (in_flat)
);

// File: tb/test_sgpio_engine.sv
`timescale 1ns/1ps
module test_sgpio_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        ser_clk, ser_dout, ser_latch;
  logic        ser_din = 1'b0;

  always #2 clk = ~clk;

  sgpio_engine i_sgpio_engine (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(wr_en), .reg_wr_addr(wr_addr), .reg_wr_data(wr_data),
    .reg_rd_addr(rd_addr), .reg_rd_data(rd_data),
    .ser_clk(ser_clk), .ser_dout(ser_dout), .ser_din(ser_din), .ser_latch(ser_latch)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cur_div = 0;
  logic [127:0] sdi_vec = '0;
  logic [127:0] exp_in = '0;

  // monitor state: the bench acts as the external shift-register chain
  logic         prev_sclk = 1'b0, prev_load = 1'b0, lo_valid = 1'b0;
  int           hi_run = 0, lo_run = 0, ld_run = 0, rec_cnt = 0, bad_t = 0;
  logic [127:0] rec_vec = '0;
  logic [127:0] last_vec = '0;
  int           last_cnt = 0, last_ld = 0, last_bad = 0, frame_cnt = 0;

  always @(negedge clk) begin
    if (ser_clk && !prev_sclk) begin
      if (lo_valid && lo_run != cur_div + 1) bad_t++;
      if (rec_cnt < 128) begin
        rec_vec[rec_cnt] = ser_dout;
        ser_din <= sdi_vec[rec_cnt];
      end
      rec_cnt++;
    end
    if (ser_clk) hi_run++;
    else if (prev_sclk) begin
      if (hi_run != cur_div + 1) bad_t++;
      hi_run = 0;
      lo_run = 0;
      lo_valid = 1'b1;
    end
    if (!ser_clk && !ser_latch) lo_run++;
    if (ser_clk && ser_latch) bad_t++;
    if (ser_latch) begin
      ld_run++;
      lo_valid = 1'b0;
    end else if (prev_load) begin
      last_vec  = rec_vec;
      last_cnt  = rec_cnt;
      last_ld   = ld_run;
      last_bad  = bad_t;
      rec_vec   = '0;
      rec_cnt   = 0;
      ld_run    = 0;
      bad_t     = 0;
      lo_run    = 0;
      frame_cnt++;
    end
    prev_sclk = ser_clk;
    prev_load = ser_latch;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL R10 watchdog expired: actual %0d expected <150000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = 4'(a);
    #1 d = rd_data;
  endtask

  function automatic logic [31:0] ctrl_word(input bit run, input int n, input int d);
    return {8'h00, 16'(d), 5'b0, 2'(n - 1), run};
  endfunction

  function automatic void build_exp(input logic [31:0] m, input int n, input logic [127:0] ow,
                                    output logic [127:0] v, output int cnt);
    v = '0; cnt = 0;
    for (int p = 0; p < 32; p++)
      if (m[p])
        for (int b = 0; b < n; b++) begin
          v[cnt] = ow[b*32 + p];
          cnt++;
        end
  endfunction

  function automatic void apply_model(input logic [31:0] m, input int n);
    int s = 0;
    for (int p = 0; p < 32; p++)
      if (m[p])
        for (int b = 0; b < n; b++) begin
          exp_in[b*32 + p] = sdi_vec[s];
          s++;
        end
  endfunction

  task automatic read_inputs(output logic [127:0] v);
    logic [31:0] w;
    for (int k = 0; k < 4; k++) begin
      rd(6 + k, w);
      v[k*32 +: 32] = w;
    end
  endtask

  task automatic wait_frame();
    int f0 = frame_cnt;
    wait (frame_cnt != f0);
    @(negedge clk);
  endtask

  task automatic stop_engine(input int n, input int d);
    wr(0, ctrl_word(1'b0, n, d));
    repeat (900) @(negedge clk);
  endtask

  task automatic start_cfg(input logic [31:0] m, input int n, input int d, input logic [127:0] ow);
    logic [127:0] mid;
    cur_div = d;
    for (int k = 0; k < 4; k++) wr(2 + k, ow[k*32 +: 32]);
    wr(1, m);
    wr(0, ctrl_word(1'b1, n, d));
    read_inputs(mid);
    chk(mid == exp_in, "R6", "inputs unchanged mid-frame", mid, exp_in);
  endtask

  task automatic check_frame(input logic [31:0] m, input int n, input int d, input logic [127:0] ow);
    logic [127:0] v, got;
    int cnt;
    build_exp(m, n, ow, v, cnt);
    chk(last_cnt == cnt, "R3", "slot count", 128'(last_cnt), 128'(cnt));
    chk(last_vec == v, "R4", "slot order", last_vec, v);
    chk(last_bad == 0, "R8", "phase widths", 128'(last_bad), 128'(0));
    chk(last_ld == 2*(d+1), "R7", "latch width", 128'(last_ld), 128'(2*(d+1)));
    apply_model(m, n);
    read_inputs(got);
    chk(got == exp_in, "R5", "captured inputs", got, exp_in);
  endtask

  task automatic run_case(input logic [31:0] m, input int n, input int d,
                          input logic [127:0] ow, input logic [127:0] pat);
    stop_engine(n, d);
    sdi_vec = pat;
    start_cfg(m, n, d, ow);
    wait_frame();
    check_frame(m, n, d, ow);
    wait_frame();
    check_frame(m, n, d, ow);   // R10: next frame follows without software action
  endtask

  initial begin
    logic [31:0] w;
    logic [127:0] ow, pat, v;
    logic [31:0] m;
    int n, d, cnt, act;
    void'($urandom(32'd20240611));

    repeat (5) @(negedge clk);
    chk(!ser_clk && !ser_dout && !ser_latch, "R1", "pins in reset",
        128'({ser_clk, ser_dout, ser_latch}), 128'(0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int a = 0; a < 10; a++) begin
      rd(a, w);
      chk(w == 0, "R1", "register reset value", 128'(w), 128'(0));
    end

    // R2 register map readback; input words ignore writes
    wr(0, ctrl_word(1'b0, 3, 16'h1234));
    rd(0, w);
    chk(w == ctrl_word(1'b0, 3, 16'h1234), "R2", "control readback", 128'(w), 128'(ctrl_word(1'b0, 3, 16'h1234)));
    wr(1, 32'hA5C3_0F81);
    rd(1, w);
    chk(w == 32'hA5C3_0F81, "R2", "mask readback", 128'(w), 128'(32'hA5C3_0F81));
    for (int k = 0; k < 4; k++) begin
      wr(2 + k, 32'h1111_1111 * (k + 1));
      rd(2 + k, w);
      chk(w == 32'h1111_1111 * (k + 1), "R2", "output word readback", 128'(w), 128'(32'h1111_1111 * (k + 1)));
    end
    wr(7, 32'hFFFF_FFFF);
    rd(7, w);
    chk(w == 0, "R2", "input word ignores write", 128'(w), 128'(0));

    // R9: zero mask with run set produces no activity
    wr(1, 32'h0);
    wr(0, ctrl_word(1'b1, 4, 0));
    act = 0;
    repeat (300) begin
      @(negedge clk);
      if (ser_clk || ser_latch || ser_dout) act++;
    end
    chk(act == 0, "R9", "idle with empty mask", 128'(act), 128'(0));
    // R9: run cleared with a mask set
    wr(0, ctrl_word(1'b0, 4, 0));
    wr(1, 32'hFFFF_FFFF);
    act = 0;
    repeat (300) begin
      @(negedge clk);
      if (ser_clk || ser_latch || ser_dout) act++;
    end
    chk(act == 0, "R9", "idle with run cleared", 128'(act), 128'(0));

    // directed: sparse ports 0,1,5,6,7 with four bits each
    ow  = {$urandom, $urandom, $urandom, $urandom};
    pat = {$urandom, $urandom, $urandom, $urandom};
    run_case(32'h0000_00E3, 4, 1, ow, pat);
    // directed: only the top port, one bit, wide divider
    run_case(32'h8000_0000, 1, 5, ~ow, ~pat);
    // directed: full 128-slot frame
    ow  = {$urandom, $urandom, $urandom, $urandom};
    pat = {$urandom, $urandom, $urandom, $urandom};
    run_case(32'hFFFF_FFFF, 4, 0, ow, pat);

    // R10 directed: mask narrowed while a frame is in flight
    stop_engine(1, 1);
    ow  = {$urandom, $urandom, $urandom, $urandom};
    pat = {$urandom, $urandom, $urandom, $urandom};
    sdi_vec = pat;
    start_cfg(32'h0000_00FF, 1, 1, ow);
    wait (rec_cnt >= 2);
    wr(1, 32'h0000_0003);
    wait_frame();
    check_frame(32'h0000_00FF, 1, 1, ow);
    build_exp(32'h0000_00FF, 1, ow, v, cnt);
    chk(last_cnt == 8, "R10", "old mask kept for frame in flight", 128'(last_cnt), 128'(8));
    wait_frame();
    check_frame(32'h0000_0003, 1, 1, ow);
    chk(last_cnt == 2, "R10", "new mask used next frame", 128'(last_cnt), 128'(2));

    // random mix
    for (int it = 0; it < 10; it++) begin
      case ($urandom % 3)
        0: m = $urandom;
        1: m = $urandom & $urandom & $urandom;
        default: m = 32'hFFFF_FFFF >> ($urandom % 32);
      endcase
      if (m == 0) m = 32'h1 << ($urandom % 32);
      n = 1 + int'($urandom % 4);
      d = int'($urandom % 3);
      ow  = {$urandom, $urandom, $urandom, $urandom};
      pat = {$urandom, $urandom, $urandom, $urandom};
      run_case(m, n, d, ow, pat);
    end

    stop_engine(1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule